// File: doc/BRIEF.md
# Configuration Access Translator for a Host-to-Bus Bridge

This block sits on the processor side of a host bridge. Software produces configuration cycles through two I/O ports. A dword-wide selector port at 0CF8h holds an enable flag, a bus number, a device number, a function number and a register index. A data port at 0CFCh–0CFFh produces the cycle itself when it is read or written. The block keeps the selector. When the data port is accessed, it checks the selected target against the bridge's bus-number window and builds a request for the downstream bus engine. That request carries the command code, the address-phase word, the active-high byte enables, the write data and a one-hot device-select vector.

A target on the bridge's own bus gets a flat (type 0) cycle. The device number is decoded into one select line, and the same pattern is placed in the upper address bits. A target on a bus further down gets a hierarchical (type 1) cycle, which a downstream bridge forwards. Targets that cannot exist raise no cycle: a read of one returns all ones and a write to one is dropped. Any other I/O access, including a narrow access to the selector port, is passed through as an ordinary I/O transaction. Only one request is outstanding at a time. The processor side holds `io_req` until it sees the single-cycle `io_ack`.

Top module: `cfg_access_xlate`

## Requirements
- R1: A write with all four byte enables to dword address 0CF8h stores the selector. Reading it back returns the stored value with bits 30–24 and 1–0 forced to zero, and it is zero after reset. Neither access issues a downstream request.
- R2: Any access that is neither a data-port access nor a four-byte selector access is forwarded as an I/O read (command 0010) or I/O write (command 0011). Its address is the byte address of the lowest enabled lane, and the selector keeps its value.
- R3: A data-port access makes a configuration request only when selector bit 31 is 1 and the bus number lies between the primary and subordinate bus numbers, both limits included. Otherwise no request is issued and a read returns FFFFFFFFh.
- R4: When the bus number equals the primary bus, the request carries a select vector with only bit `dev` set. The address is that vector in bits 31–11, the function in bits 10–8, the register index in bits 7–2 and 00 in bits 1–0.
- R5: On the primary bus, device numbers 21 to 31 count as absent. There is no request, and a read returns FFFFFFFFh.
- R6: When the bus number is above the primary bus and within range, the address is zero in bits 31–24, bus/device/function/register in bits 23–2 and 01 in bits 1–0. The select vector is all zero.
- R7: A configuration read uses command 1010 and a configuration write uses 1011. The request byte enables equal `io_be`, where bit i stands for byte 0CFCh+i. The write data is `io_wdata` unchanged.
- R8: A downstream completion flagged as a master abort returns FFFFFFFFh for a read. A normal read completion returns `bus_rdata`.
- R9: `bus_req` stays high with stable fields until `bus_done` is sampled, and `io_ack` follows one cycle later. No new request starts until the processor has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_req | input | 1 | Processor I/O access pending, held until `io_ack` |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW-2 | Dword I/O address (byte address bits IO_AW-1..2) |
| io_be | input | 4 | Active-high byte enables within the dword |
| io_wdata | input | 32 | Processor write data |
| io_ack | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with `io_ack` |
| pri_bus | input | 8 | Bus number directly below the bridge |
| sub_bus | input | 8 | Highest bus number reachable through the bridge |
| bus_req | output | 1 | Downstream request pending |
| bus_cmd | output | 4 | Bus command code |
| bus_addr | output | 32 | Address-phase word |
| bus_be | output | 4 | Active-high byte enables |
| bus_idsel | output | 21 | One-hot device select for flat cycles |
| bus_wdata | output | 32 | Write data for the data phase |
| bus_done | input | 1 | Downstream completion strobe |
| bus_abort | input | 1 | Completion ended in master abort (with `bus_done`) |
| bus_rdata | input | 32 | Downstream read data (with `bus_done`) |

## Verification
Two things can meet in the same cycle: the completion of a forwarded cycle and the processor still holding its request. An FSM that re-accepted that held request would issue a second cycle. The bench drives completions at delays from zero to ten cycles and keeps `io_req` asserted until it sees the acknowledge. For every transaction it checks that the number of downstream requests matches what the reference model expects. Selector writes whose data-port follow-ups land on the window edges, and on device numbers 20 and 21, cover the boundary between type 0, type 1 and "absent" decoding.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  localparam int unsigned DEV_LSB  = 11;
  localparam int unsigned IDSEL_W  = 32 - DEV_LSB;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] rg;
  } cfg_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } xact_state_e;

  typedef struct packed {
    logic               local_only;
    logic [3:0]         cmd;
    logic [31:0]        addr;
    logic [IDSEL_W-1:0] idsel;
    logic [3:0]         be;
    logic [31:0]        ldata;
  } xact_t;

  function automatic logic [1:0] low_lane(input logic [3:0] be);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (be[i]) r = 2'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_addr_port.sv
module cfg_addr_port
  import cfg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output cfg_sel_t    sel,
  output logic [31:0] rdback
);

  cfg_sel_t sel_q;
  cfg_sel_t sel_d;

  always_comb begin
    sel_d     = sel_q;
    if (wr_en) begin
      sel_d.en  = wdata[31];
      sel_d.bus = wdata[23:16];
      sel_d.dev = wdata[15:11];
      sel_d.fn  = wdata[10:8];
      sel_d.rg  = wdata[7:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel    = sel_q;
  assign rdback = {sel_q.en, 7'b0, sel_q.bus, sel_q.dev, sel_q.fn, sel_q.rg, 2'b00};

endmodule

// File: rtl/cfg_target_decode.sv
module cfg_target_decode
  import cfg_xlate_pkg::*;
(
  input  cfg_sel_t           sel,
  input  logic [7:0]         pri_bus,
  input  logic [7:0]         sub_bus,
  output logic               hit,
  output logic               hier,
  output logic [31:0]        addr,
  output logic [IDSEL_W-1:0] idsel
);

  logic [IDSEL_W-1:0] dev_hot;
  logic               dev_ok;
  logic               in_range;

  for (genvar g = 0; g < IDSEL_W; g++) begin : g_dev_hot
    assign dev_hot[g] = (sel.dev == 5'(g));
  end

  always_comb begin
    dev_ok   = |dev_hot;
    in_range = (sel.bus >= pri_bus) && (sel.bus <= sub_bus);
    hier     = (sel.bus != pri_bus);
    hit      = sel.en && in_range && (hier || dev_ok);
    idsel    = hier ? '0 : dev_hot;
    if (hier) addr = {8'h00, sel.bus, sel.dev, sel.fn, sel.rg, 2'b01};
    else      addr = {dev_hot, sel.fn, sel.rg, 2'b00};
  end

endmodule

// File: rtl/cfg_xact_fsm.sv
module cfg_xact_fsm
  import cfg_xlate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_req,
  input  logic               io_wr,
  input  logic [31:0]        io_wdata,
  input  xact_t              nxt,
  output logic               accept,
  output logic               io_ack,
  output logic [31:0]        io_rdata,
  output logic               bus_req,
  output logic [3:0]         bus_cmd,
  output logic [31:0]        bus_addr,
  output logic [3:0]         bus_be,
  output logic [IDSEL_W-1:0] bus_idsel,
  output logic [31:0]        bus_wdata,
  input  logic               bus_done,
  input  logic               bus_abort,
  input  logic [31:0]        bus_rdata
);

  xact_state_e state_q, state_d;
  logic        ld_fwd;
  logic        ld_resp;
  logic [31:0] resp_d;
  logic [31:0] resp_q;
  xact_t       cur_q;
  logic [31:0] wdat_q;

  always_comb begin
    state_d = state_q;
    ld_fwd  = 1'b0;
    ld_resp = 1'b0;
    resp_d  = resp_q;
    unique case (state_q)
      ST_IDLE: begin
        if (io_req) begin
          if (nxt.local_only) begin
            state_d = ST_DONE;
            ld_resp = 1'b1;
            resp_d  = nxt.ldata;
          end else begin
            state_d = ST_WAIT;
            ld_fwd  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (bus_done) begin
          state_d = ST_DONE;
          ld_resp = 1'b1;
          resp_d  = (bus_abort && !cur_q.cmd[0]) ? ALL_ONES : bus_rdata;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      wdat_q <= '0;
    end else if (ld_fwd) begin
      cur_q  <= nxt;
      wdat_q <= io_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       resp_q <= '0;
    else if (ld_resp) resp_q <= resp_d;
  end

  assign accept    = (state_q == ST_IDLE) && io_req;
  assign io_ack    = (state_q == ST_DONE);
  assign io_rdata  = resp_q;
  assign bus_req   = (state_q == ST_WAIT);
  assign bus_cmd   = cur_q.cmd;
  assign bus_addr  = cur_q.addr;
  assign bus_be    = cur_q.be;
  assign bus_idsel = cur_q.idsel;
  assign bus_wdata = wdat_q;

  // R9: request and its fields hold until the engine completes it
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_cmd) && $stable(bus_be)));

  // R9: the acknowledge follows the completion strobe by exactly one cycle
  assert_ack_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done) |=> (io_ack && !bus_req));

  // R8: a master-aborted read comes back as all ones
  assert_abort_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done && bus_abort && !bus_cmd[0]) |=> (io_rdata == ALL_ONES));

  // R9: a request only starts from a pending processor access
  assert_req_from_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(io_req));

endmodule

// File: rtl/cfg_access_xlate.sv
module cfg_access_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned      IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 'h0CFC
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_req,
  input  logic               io_wr,
  input  logic [IO_AW-1:2]   io_addr,
  input  logic [3:0]         io_be,
  input  logic [31:0]        io_wdata,
  output logic               io_ack,
  output logic [31:0]        io_rdata,
  input  logic [7:0]         pri_bus,
  input  logic [7:0]         sub_bus,
  output logic               bus_req,
  output logic [3:0]         bus_cmd,
  output logic [31:0]        bus_addr,
  output logic [3:0]         bus_be,
  output logic [IDSEL_W-1:0] bus_idsel,
  output logic [31:0]        bus_wdata,
  input  logic               bus_done,
  input  logic               bus_abort,
  input  logic [31:0]        bus_rdata
);

  localparam int unsigned PAD_W = 32 - IO_AW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  cfg_sel_t           sel;
  logic [31:0]        sel_rd;
  logic               dec_hit;
  logic               dec_hier;
  logic [31:0]        dec_addr;
  logic [IDSEL_W-1:0] dec_idsel;
  logic               is_aport;
  logic               is_dport;
  logic               aport_full;
  logic               accept;
  logic               sel_wr;
  xact_t              nxt;

  assign is_aport   = (io_addr == ADDR_PORT[IO_AW-1:2]);
  assign is_dport   = (io_addr == DATA_PORT[IO_AW-1:2]);
  assign aport_full = is_aport && (io_be == 4'hF);
  assign sel_wr     = accept && aport_full && io_wr;

  cfg_addr_port u_sel (
    .clk    (clk),
    .rst_n  (rst_s),
    .wr_en  (sel_wr),
    .wdata  (io_wdata),
    .sel    (sel),
    .rdback (sel_rd)
  );

  cfg_target_decode u_dec (
    .sel     (sel),
    .pri_bus (pri_bus),
    .sub_bus (sub_bus),
    .hit     (dec_hit),
    .hier    (dec_hier),
    .addr    (dec_addr),
    .idsel   (dec_idsel)
  );

  always_comb begin
    nxt.local_only = 1'b0;
    nxt.cmd        = io_wr ? CMD_IO_WR : CMD_IO_RD;
    nxt.addr       = {{PAD_W{1'b0}}, io_addr, low_lane(io_be)};
    nxt.idsel      = '0;
    nxt.be         = io_be;
    nxt.ldata      = sel_rd;
    if (aport_full) begin
      nxt.local_only = 1'b1;
    end else if (is_dport) begin
      if (dec_hit) begin
        nxt.cmd   = io_wr ? CMD_CFG_WR : CMD_CFG_RD;
        nxt.addr  = dec_addr;
        nxt.idsel = dec_idsel;
      end else begin
        nxt.local_only = 1'b1;
        nxt.ldata      = ALL_ONES;
      end
    end
  end

  cfg_xact_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_s),
    .io_req    (io_req),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .nxt       (nxt),
    .accept    (accept),
    .io_ack    (io_ack),
    .io_rdata  (io_rdata),
    .bus_req   (bus_req),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_idsel (bus_idsel),
    .bus_wdata (bus_wdata),
    .bus_done  (bus_done),
    .bus_abort (bus_abort),
    .bus_rdata (bus_rdata)
  );

  // R4: flat cycles select exactly one device and mirror it in the address
  assert_flat_onehot_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_req && bus_cmd[3:1] == 3'b101 && bus_addr[1:0] == 2'b00)
      |-> ($onehot(bus_idsel) && bus_addr[31:DEV_LSB] == bus_idsel));

  // R6: hierarchical cycles drive no select line and leave the top byte clear
  assert_hier_clear_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_req && bus_cmd[3:1] == 3'b101 && bus_addr[1:0] == 2'b01)
      |-> (bus_idsel == '0 && bus_addr[31:24] == 8'h00));

  // R3: a configuration request only appears while the selector is enabled
  assert_cfg_enabled_R3: assert property (@(posedge clk) disable iff (!rst_s)
    ($rose(bus_req) && bus_cmd[3:1] == 3'b101) |-> sel.en);

  // R2: pass-through I/O never carries a select vector
  assert_io_noselect_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_req && bus_cmd[3:1] == 3'b001) |-> (bus_idsel == '0));

endmodule

// File: tb/cfg_access_xlate_tb.sv
module cfg_access_xlate_tb;

  localparam int IW = 21;

  logic          clk;
  logic          rst_n;
  logic          io_req;
  logic          io_wr;
  logic [15:2]   io_addr;
  logic [3:0]    io_be;
  logic [31:0]   io_wdata;
  logic          io_ack;
  logic [31:0]   io_rdata;
  logic [7:0]    pri_bus;
  logic [7:0]    sub_bus;
  logic          bus_req;
  logic [3:0]    bus_cmd;
  logic [31:0]   bus_addr;
  logic [3:0]    bus_be;
  logic [IW-1:0] bus_idsel;
  logic [31:0]   bus_wdata;
  logic          bus_done;
  logic          bus_abort;
  logic [31:0]   bus_rdata;

  int nchk;
  int nfail;
  logic [31:0] sel_m;

  cfg_access_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
    .pri_bus(pri_bus), .sub_bus(sub_bus),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_idsel(bus_idsel), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_abort(bus_abort), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] sel_word(input bit en, input logic [7:0] bus,
                                           input logic [4:0] dev, input logic [2:0] fn,
                                           input logic [5:0] rg);
    // reserved and low bits deliberately dirty: they must be dropped
    return {en, 7'h5A, bus, dev, fn, rg, 2'b11};
  endfunction

  function automatic logic [1:0] lane_of(input logic [3:0] be);
    if (be[0]) return 2'd0;
    if (be[1]) return 2'd1;
    if (be[2]) return 2'd2;
    if (be[3]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic xfer(input logic [15:0] a, input logic [3:0] be, input bit wr,
                      input logic [31:0] wd, input bit abort, input int delay,
                      input logic [31:0] rdv);
    bit          exp_fwd;
    logic [3:0]  exp_cmd;
    logic [31:0] exp_addr;
    logic [IW-1:0] exp_ids;
    logic [31:0] exp_rd;
    string       tag;
    bit          en;
    logic [7:0]  bus;
    logic [4:0]  dev;
    bit          seen;
    bit          resp;
    bit          acked;
    int          wcnt;
    logic [3:0]  c_cmd;
    logic [31:0] c_addr;
    logic [3:0]  c_be;
    logic [IW-1:0] c_ids;
    logic [31:0] c_wd;
    logic [31:0] got;

    en  = sel_m[31];
    bus = sel_m[23:16];
    dev = sel_m[15:11];
    exp_ids = '0;
    exp_rd  = 32'hFFFF_FFFF;
    if (a[15:2] == 14'(16'h0CF8 >> 2) && be == 4'hF) begin
      exp_fwd = 1'b0; exp_rd = sel_m; tag = "R1";
      exp_cmd = 4'h0; exp_addr = 32'h0;
    end else if (a[15:2] == 14'(16'h0CFC >> 2)) begin
      exp_cmd = wr ? 4'b1011 : 4'b1010;
      if (!en || bus < pri_bus || bus > sub_bus) begin
        exp_fwd = 1'b0; tag = "R3"; exp_addr = 32'h0;
      end else if (bus == pri_bus) begin
        if (dev > 5'd20) begin
          exp_fwd = 1'b0; tag = "R5"; exp_addr = 32'h0;
        end else begin
          exp_fwd = 1'b1; tag = "R4";
          exp_ids = IW'(1) << dev;
          exp_addr = (32'h1 << (11 + dev)) | (sel_m & 32'h0000_07FC);
        end
      end else begin
        exp_fwd = 1'b1; tag = "R6";
        exp_addr = (sel_m & 32'h00FF_FFFC) | 32'h1;
      end
    end else begin
      exp_fwd = 1'b1; tag = "R2";
      exp_cmd = wr ? 4'b0011 : 4'b0010;
      exp_addr = {16'h0, a[15:2], lane_of(be)};
    end
    if (exp_fwd) exp_rd = abort ? 32'hFFFF_FFFF : rdv;

    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_addr = a[15:2]; io_be = be; io_wdata = wd;
    seen = 0; resp = 0; acked = 0; wcnt = 0;
    c_cmd = '0; c_addr = '0; c_be = '0; c_ids = '0; c_wd = '0;
    for (int it = 0; it < 64; it++) begin
      @(negedge clk);
      bus_done = 1'b0; bus_abort = 1'b0;
      if (io_ack) begin acked = 1; break; end
      if (bus_req && !seen) begin
        seen = 1;
        c_cmd = bus_cmd; c_addr = bus_addr; c_be = bus_be; c_ids = bus_idsel; c_wd = bus_wdata;
      end
      if (seen && !resp) begin
        chk(bus_req && bus_addr == c_addr && bus_cmd == c_cmd, "R9 request held", bus_addr, c_addr);
        if (wcnt == delay) begin
          bus_done = 1'b1; bus_abort = abort; bus_rdata = rdv; resp = 1;
        end else wcnt++;
      end else if (resp && bus_req) begin
        chk(1'b0, "R9 second request", 32'h1, 32'h0);
      end
    end
    got = io_rdata;
    io_req = 1'b0; bus_done = 1'b0; bus_abort = 1'b0;
    chk(acked, "R9 acknowledge", 32'(acked), 32'h1);
    chk(seen == exp_fwd, {tag, " request issued"}, 32'(seen), 32'(exp_fwd));
    if (exp_fwd && seen) begin
      chk(c_cmd == exp_cmd, (tag == "R2") ? "R2 cmd" : "R7 cmd", 32'(c_cmd), 32'(exp_cmd));
      chk(c_addr == exp_addr, {tag, " addr"}, c_addr, exp_addr);
      chk(c_ids == exp_ids, {tag, " idsel"}, 32'(c_ids), 32'(exp_ids));
      chk(c_be == be, "R7 byte enables", 32'(c_be), 32'(be));
      if (wr) chk(c_wd == wd, "R7 write data", c_wd, wd);
    end
    if (!wr) chk(got == exp_rd, exp_fwd ? "R8 read data" : {tag, " read data"}, got, exp_rd);
    if (a[15:2] == 14'(16'h0CF8 >> 2) && be == 4'hF && wr) sel_m = wd & 32'h80FF_FFFC;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0; sel_m = 32'h0;
    io_req = 0; io_wr = 0; io_addr = '0; io_be = 4'h0; io_wdata = '0;
    bus_done = 0; bus_abort = 0; bus_rdata = '0;
    pri_bus = 8'd2; sub_bus = 8'd5;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(io_ack == 1'b0 && bus_req == 1'b0, "R9 reset idle", {30'h0, io_ack, bus_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset value and reserved-bit masking
    xfer(16'h0CF8, 4'hF, 0, 0, 0, 0, 0);
    xfer(16'h0CF8, 4'hF, 1, 32'hFFFF_FFFF, 0, 0, 0);
    xfer(16'h0CF8, 4'hF, 0, 0, 0, 0, 0);
    xfer(16'h0CFC, 4'hF, 0, 0, 0, 0, 32'h1234_5678);   // R3 bus FFh out of range
    // R4 device 20 edge, R5 device 21
    xfer(16'h0CF8, 4'hF, 1, sel_word(1, 8'd2, 5'd20, 3'd3, 6'h11), 0, 0, 0);
    xfer(16'h0CFC, 4'hF, 0, 0, 0, 1, 32'hCAFE_0001);
    xfer(16'h0CFC, 4'b0110, 1, 32'hA5A5_5A5A, 0, 0, 0); // R7 partial enables
    xfer(16'h0CFC, 4'hF, 0, 0, 1, 2, 32'h0BAD_0BAD);   // R8 abort
    xfer(16'h0CF8, 4'hF, 1, sel_word(1, 8'd2, 5'd21, 3'd0, 6'h00), 0, 0, 0);
    xfer(16'h0CFC, 4'hF, 0, 0, 0, 0, 32'h0);
    xfer(16'h0CFC, 4'hF, 1, 32'h1, 0, 0, 0);
    // R6 at subordinate limit, R3 just outside both ends and disabled
    xfer(16'h0CF8, 4'hF, 1, sel_word(1, 8'd5, 5'd31, 3'd7, 6'h3F), 0, 0, 0);
    xfer(16'h0CFC, 4'hF, 0, 0, 0, 10, 32'h5555_AAAA); // R9 long stall
    xfer(16'h0CF8, 4'hF, 1, sel_word(1, 8'd6, 5'd1, 3'd0, 6'h01), 0, 0, 0);
    xfer(16'h0CFC, 4'hF, 0, 0, 0, 0, 32'h0);
    xfer(16'h0CF8, 4'hF, 1, sel_word(1, 8'd1, 5'd1, 3'd0, 6'h01), 0, 0, 0);
    xfer(16'h0CFC, 4'hF, 0, 0, 0, 0, 32'h0);
    xfer(16'h0CF8, 4'hF, 1, sel_word(0, 8'd2, 5'd1, 3'd0, 6'h01), 0, 0, 0);
    xfer(16'h0CFC, 4'hF, 0, 0, 0, 0, 32'h0);
    // R2: narrow selector accesses pass through and leave the selector alone
    xfer(16'h0CF8, 4'b0011, 1, 32'hDEAD_BEEF, 0, 0, 0);
    xfer(16'h0CF8, 4'b1000, 0, 0, 0, 1, 32'h0000_00EE);
    xfer(16'h0CF8, 4'hF, 0, 0, 0, 0, 0);
    xfer(16'h0080, 4'b1100, 0, 0, 1, 0, 32'h0);

    void'($urandom(32'h00C0_FFEE));
    for (int n = 0; n < 400; n++) begin
      int          k;
      logic [3:0]  be;
      logic [15:0] a;
      k  = int'($urandom_range(0, 9));
      be = 4'($urandom_range(1, 15));
      if (k < 3) begin
        logic [7:0] b;
        b = 8'($urandom_range(0, 7));
        xfer(16'h0CF8, 4'hF, 1,
             sel_word(($urandom_range(0, 5) != 0), b, 5'($urandom_range(0, 31)),
                      3'($urandom), 6'($urandom)), 0, 0, 0);
      end else if (k < 8) begin
        xfer(16'h0CFC, be, ($urandom_range(0, 1) == 1), $urandom, ($urandom_range(0, 3) == 0),
             int'($urandom_range(0, 4)), $urandom);
      end else if (k == 8) begin
        xfer(16'h0CF8, ($urandom_range(0, 1) == 1) ? 4'hF : (be & 4'h7),
             ($urandom_range(0, 1) == 1), $urandom, 0, int'($urandom_range(0, 2)), $urandom);
      end else begin
        a = {2'b00, 12'($urandom_range(0, 4095)), 2'b00};
        if (a[15:2] == 14'h33E || a[15:2] == 14'h33F) a = 16'h0100;
        xfer(a, be, ($urandom_range(0, 1) == 1), $urandom, ($urandom_range(0, 1) == 1),
             int'($urandom_range(0, 3)), $urandom);
      end
      if (n % 50 == 49) begin
        pri_bus = 8'($urandom_range(0, 3));
        sub_bus = pri_bus + 8'($urandom_range(0, 3));
      end
    end

    summary();
    $finish;
  end

endmodule